// File: doc/BRIEF.md
# Bayer Defect Pixel Corrector

This block is a streaming filter for raw Bayer image data. It takes 10-bit samples, one for each clock cycle that carries a valid flag. Each sample comes with markers for the first and last pixel of a line. The filter compares every pixel with the nearest pixels of the same colour on the same row. In a Bayer mosaic those pixels sit two columns to the left and two columns to the right.

A pixel is treated as defective when it stands out from both neighbours, above both or below both, by more than a programmable threshold. A defective pixel is replaced by the rounded average of those two neighbours. Detection is done on every pixel as it passes, with no stored table of defect addresses, so there is no limit on how many pixels can be repaired. An enable input turns correction off; pixels then pass through unchanged with the same latency. Each output pixel leaves exactly three accepted input pixels after it entered, and its line markers travel with it.

Internally, a fill state machine tracks how full the five-tap window is after reset. Its states are FILL_EMPTY, FILL_ONE, FILL_TWO, FILL_THREE, FILL_FOUR and FILL_FULL. Each transition is "accept": a cycle with the valid flag moves the machine one state up and saturates in FILL_FULL. The only other transition is "reset", which returns it to FILL_EMPTY from any state. In FILL_THREE and above a centre pixel exists and is emitted. Only in FILL_FULL are both neighbours present and correction allowed. A per-pixel classifier labels the centre PX_BYPASS, PX_EDGE, PX_KEEP, PX_HOT or PX_COLD, and that label picks the output value.

Top module: `bayer_defect_fix`

## Requirements
- R1: Synchronous active-high reset clears the pixel window and drives out_valid and out_data to 0. After reset, the first three accepted pixels produce no output.
- R2: Each accepted pixel is emitted, in order, in the cycle after the third following accepted pixel. out_valid is high only in a cycle that follows an accepted input.
- R3: out_sol and out_eol equal the in_sol and in_eol values that entered with the emitted pixel.
- R4: With correction enabled, an eligible pixel C whose neighbours are L (two accepted pixels earlier) and R (two later) is hot when C > L + T and C > R + T, where T is thresh. A hot pixel is replaced.
- R5: An eligible pixel is cold when C + T < L and C + T < R. A cold pixel is replaced.
- R6: The replacement value is (L + R + 1) >> 1, formed at 11 bits and kept to 10 bits. It never lies outside the range spanned by L and R.
- R7: A pixel whose difference from either neighbour is at most T (equal to T included) is output unchanged.
- R8: A pixel is output unchanged when any of these hold: it is one of the first two or last two pixels of its line, or fewer than five pixels have been accepted since reset when its right neighbour arrives. Line position is judged from the markers: sol set on the pixel or its left-adjacent pixel, or eol set on the pixel or its right-adjacent pixel.
- R9: With corr_en low, every pixel is output unchanged with the same latency and markers.
- R10: A cycle with in_valid low does not advance the window, and out_valid is low in the following cycle.
- R11: Detection always uses the raw input neighbours. Defects on every same-colour pixel of a row are all repaired.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| corr_en | input | 1 | 1 = correct defects, 0 = pass through |
| thresh | input | 10 | Detection threshold T |
| in_valid | input | 1 | Input pixel accepted this cycle |
| in_data | input | 10 | Raw Bayer sample |
| in_sol | input | 1 | Input pixel is first of its line |
| in_eol | input | 1 | Input pixel is last of its line |
| out_valid | output | 1 | Output pixel valid |
| out_data | output | 10 | Corrected or passed sample |
| out_sol | output | 1 | Output pixel is first of its line |
| out_eol | output | 1 | Output pixel is last of its line |

## Verification
The bench builds the block with its default 10-bit sample width. This brings the threshold extremes 0 and 1023 and full-scale pixel values into reach. The bench sweeps four thresholds with correction on and off. It sends every line length from 1 to 14, so lines shorter than the window and lines where edge and interior pixels meet are all covered. It also sends spike patterns that sit at T and at T+1 from both neighbours, rows where every same-colour pixel is defective, idle gaps, and a reset in the middle of a stream.

// File: rtl/bpc_pkg.sv
package bpc_pkg;
    localparam int TAPS = 5;

    typedef enum logic [2:0] {
        FILL_EMPTY,
        FILL_ONE,
        FILL_TWO,
        FILL_THREE,
        FILL_FOUR,
        FILL_FULL
    } fill_e;

    typedef enum logic [2:0] {
        PX_BYPASS,
        PX_EDGE,
        PX_KEEP,
        PX_HOT,
        PX_COLD
    } pxkind_e;
endpackage

// File: rtl/bpc_window.sv
module bpc_window
    import bpc_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sol,
    input  logic              in_eol,
    output logic [DATA_W-1:0] left_px,
    output logic [DATA_W-1:0] mid_px,
    output logic [DATA_W-1:0] right_px,
    output logic              mid_sol,
    output logic              mid_eol,
    output logic              mid_present,
    output logic              span_ok
);
    localparam int LAST = TAPS - 1;
    localparam int MID  = TAPS / 2;

    fill_e state_q, state_d;

    // Shift taps: stage 0 holds the newest pixel, stage LAST the oldest.
    for (genvar i = 0; i < TAPS; i++) begin : g_tap
        logic [DATA_W-1:0] px_q;
        logic              sol_q;
        logic              eol_q;
        if (i == 0) begin : g_head
            always_ff @(posedge clk) begin
                if (rst) begin
                    px_q  <= '0;
                    sol_q <= 1'b0;
                    eol_q <= 1'b0;
                end else if (adv) begin
                    px_q  <= in_data;
                    sol_q <= in_sol;
                    eol_q <= in_eol;
                end
            end
        end else begin : g_body
            always_ff @(posedge clk) begin
                if (rst) begin
                    px_q  <= '0;
                    sol_q <= 1'b0;
                    eol_q <= 1'b0;
                end else if (adv) begin
                    px_q  <= g_tap[i-1].px_q;
                    sol_q <= g_tap[i-1].sol_q;
                    eol_q <= g_tap[i-1].eol_q;
                end
            end
        end
    end

    // Fill state register
    always_ff @(posedge clk) begin
        if (rst) state_q <= FILL_EMPTY;
        else     state_q <= state_d;
    end

    // Fill transitions: each accepted pixel moves one step, saturating at FULL
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FILL_EMPTY: if (adv) state_d = FILL_ONE;
            FILL_ONE:   if (adv) state_d = FILL_TWO;
            FILL_TWO:   if (adv) state_d = FILL_THREE;
            FILL_THREE: if (adv) state_d = FILL_FOUR;
            FILL_FOUR:  if (adv) state_d = FILL_FULL;
            FILL_FULL:           state_d = FILL_FULL;
            default:             state_d = FILL_EMPTY;
        endcase
    end

    // Outputs decoded from the fill state and taps
    always_comb begin
        left_px     = g_tap[LAST].px_q;
        mid_px      = g_tap[MID].px_q;
        right_px    = g_tap[0].px_q;
        mid_sol     = g_tap[MID].sol_q;
        mid_eol     = g_tap[MID].eol_q;
        mid_present = 1'b0;
        span_ok     = 1'b0;
        unique case (state_q)
            FILL_EMPTY, FILL_ONE, FILL_TWO: begin
                mid_present = 1'b0;
            end
            FILL_THREE, FILL_FOUR: begin
                mid_present = 1'b1;
            end
            FILL_FULL: begin
                mid_present = 1'b1;
                span_ok = !g_tap[MID].sol_q && !g_tap[MID+1].sol_q &&
                          !g_tap[MID].eol_q && !g_tap[MID-1].eol_q;
            end
            default: begin
                mid_present = 1'b0;
            end
        endcase
    end

    assert_fill_moves_R1: assert property (@(posedge clk) disable iff (rst)
        (adv && state_q != FILL_FULL) |=> (state_q != $past(state_q)));

    assert_idle_holds_R10: assert property (@(posedge clk) disable iff (rst)
        (!adv) |=> ($stable(state_q) && $stable(g_tap[MID].px_q)));
endmodule

// File: rtl/bpc_detect.sv
module bpc_detect
    import bpc_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              enable,
    input  logic [DATA_W-1:0] thresh,
    input  logic [DATA_W-1:0] left_px,
    input  logic [DATA_W-1:0] mid_px,
    input  logic [DATA_W-1:0] right_px,
    input  logic              span_ok,
    output pxkind_e           kind,
    output logic [DATA_W-1:0] result
);
    localparam int EXT_W = DATA_W + 1;
    localparam logic [EXT_W-1:0] ONE = {{DATA_W{1'b0}}, 1'b1};

    logic [EXT_W-1:0] l_ext, m_ext, r_ext, t_ext;
    logic [EXT_W-1:0] l_up, r_up, m_up, avg_sum;
    logic             hot, cold;

    always_comb begin
        l_ext   = {1'b0, left_px};
        m_ext   = {1'b0, mid_px};
        r_ext   = {1'b0, right_px};
        t_ext   = {1'b0, thresh};
        l_up    = l_ext + t_ext;
        r_up    = r_ext + t_ext;
        m_up    = m_ext + t_ext;
        avg_sum = l_ext + r_ext + ONE;
        hot     = (m_ext > l_up) && (m_ext > r_up);
        cold    = (m_up < l_ext) && (m_up < r_ext);
    end

    always_comb begin
        if (!enable)      kind = PX_BYPASS;
        else if (!span_ok) kind = PX_EDGE;
        else if (hot)     kind = PX_HOT;
        else if (cold)    kind = PX_COLD;
        else              kind = PX_KEEP;
    end

    always_comb begin
        unique case (kind)
            PX_HOT, PX_COLD:            result = avg_sum[DATA_W:1];
            PX_BYPASS, PX_EDGE, PX_KEEP: result = mid_px;
            default:                    result = mid_px;
        endcase
    end
endmodule

// File: rtl/bpc_out.sv
module bpc_out #(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              adv,
    input  logic              mid_present,
    input  logic [DATA_W-1:0] value,
    input  logic              sol,
    input  logic              eol,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sol,
    output logic              out_eol
);
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_sol   <= 1'b0;
            out_eol   <= 1'b0;
        end else begin
            out_valid <= adv && mid_present;
            if (adv && mid_present) begin
                out_data <= value;
                out_sol  <= sol;
                out_eol  <= eol;
            end
        end
    end

    assert_valid_after_input_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(adv));
endmodule

// File: rtl/bayer_defect_fix.sv
module bayer_defect_fix
    import bpc_pkg::*;
#(
    parameter int DATA_W = 10
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              corr_en,
    input  logic [DATA_W-1:0] thresh,
    input  logic              in_valid,
    input  logic [DATA_W-1:0] in_data,
    input  logic              in_sol,
    input  logic              in_eol,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              out_sol,
    output logic              out_eol
);
    logic [DATA_W-1:0] left_px, mid_px, right_px, fixed_px;
    logic [DATA_W-1:0] nb_lo, nb_hi;
    logic              mid_sol, mid_eol, mid_present, span_ok;
    pxkind_e           kind;

    bpc_window #(.DATA_W(DATA_W)) u_window (
        .clk(clk), .rst(rst), .adv(in_valid),
        .in_data(in_data), .in_sol(in_sol), .in_eol(in_eol),
        .left_px(left_px), .mid_px(mid_px), .right_px(right_px),
        .mid_sol(mid_sol), .mid_eol(mid_eol),
        .mid_present(mid_present), .span_ok(span_ok)
    );

    bpc_detect #(.DATA_W(DATA_W)) u_detect (
        .enable(corr_en), .thresh(thresh),
        .left_px(left_px), .mid_px(mid_px), .right_px(right_px),
        .span_ok(span_ok), .kind(kind), .result(fixed_px)
    );

    bpc_out #(.DATA_W(DATA_W)) u_out (
        .clk(clk), .rst(rst), .adv(in_valid), .mid_present(mid_present),
        .value(fixed_px), .sol(mid_sol), .eol(mid_eol),
        .out_valid(out_valid), .out_data(out_data),
        .out_sol(out_sol), .out_eol(out_eol)
    );

    always_comb begin
        nb_lo = (left_px < right_px) ? left_px : right_px;
        nb_hi = (left_px < right_px) ? right_px : left_px;
    end

    assert_markers_follow_R3: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mid_present) |=>
            (out_valid && out_sol == $past(mid_sol) && out_eol == $past(mid_eol)));

    assert_hot_lowered_R4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == PX_HOT) |=> (out_data < $past(mid_px)));

    assert_cold_raised_R5: assert property (@(posedge clk) disable iff (rst)
        (in_valid && kind == PX_COLD) |=> (out_data > $past(mid_px)));

    assert_fix_in_span_R6: assert property (@(posedge clk) disable iff (rst)
        (in_valid && (kind == PX_HOT || kind == PX_COLD)) |=>
            (out_data >= $past(nb_lo) && out_data <= $past(nb_hi)));

    assert_edge_untouched_R8: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mid_present && !span_ok) |=> (out_data == $past(mid_px)));

    assert_bypass_exact_R9: assert property (@(posedge clk) disable iff (rst)
        (in_valid && !corr_en && mid_present) |=>
            (out_valid && out_data == $past(mid_px)));
endmodule

// File: tb/bayer_defect_fix_bench.sv
`timescale 1ns/1ps
module bayer_defect_fix_bench;
    localparam int MAXG = 8192;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       corr_en = 1'b0;
    logic [9:0] thresh = '0;
    logic       in_valid = 1'b0;
    logic [9:0] in_data = '0;
    logic       in_sol = 1'b0;
    logic       in_eol = 1'b0;
    logic       out_valid;
    logic [9:0] out_data;
    logic       out_sol, out_eol;

    always #2.5 clk = ~clk;

    bayer_defect_fix u_bayer_defect_fix (
        .clk(clk), .rst(rst), .corr_en(corr_en), .thresh(thresh),
        .in_valid(in_valid), .in_data(in_data), .in_sol(in_sol), .in_eol(in_eol),
        .out_valid(out_valid), .out_data(out_data), .out_sol(out_sol), .out_eol(out_eol)
    );

    int g_val [MAXG];
    bit g_sol [MAXG];
    bit g_eol [MAXG];
    bit g_all [MAXG];
    int gj;
    int checks = 0;
    int fails = 0;
    bit done = 0;
    bit cfg_en;
    int cfg_th;
    int lf = 32'h1ACE;

    bit    pend_valid = 0;
    int    pend_data;
    bit    pend_sol, pend_eol;
    string pend_tag = "R1";

    function automatic int rnd();
        lf = (lf >> 1) ^ ((lf & 1) ? 32'h80200003 : 0);
        return lf & 32'h7FFFFFFF;
    endfunction

    function automatic int clamp(int v);
        if (v < 0) return 0;
        if (v > 1023) return 1023;
        return v;
    endfunction

    task automatic check(bit ok, string tag, int act, int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Expected output for global pixel k, using the configuration present
    // at the cycle when it is captured.
    task automatic expect_px(int k, output int val, output string tag);
        int  c, l, r;
        bit  elig, hot, cold;
        c    = g_val[k];
        val  = c;
        elig = (k >= 2) && !g_sol[k] && !g_sol[k-1] && !g_eol[k] && !g_eol[k+1];
        if (!cfg_en) begin
            tag = "R9";
            return;
        end
        if (!elig) begin
            tag = "R8";
            return;
        end
        l    = g_val[k-2];
        r    = g_val[k+2];
        hot  = (c > l + cfg_th) && (c > r + cfg_th);
        cold = (c + cfg_th < l) && (c + cfg_th < r);
        if (hot || cold) begin
            val = (l + r + 1) / 2;
            if (g_all[k])  tag = "R11";
            else if (hot)  tag = "R4 R6";
            else           tag = "R5 R6";
        end else begin
            tag = "R7";
        end
    endtask

    // Called at a negedge: checks last cycle's expectation, applies new inputs.
    task automatic step(bit v, int d, bit s, bit e, bit all_flag);
        if (pend_valid) begin
            check(out_valid === 1'b1, {pend_tag, " R2 valid"}, out_valid, 1);
            check(out_data === pend_data[9:0], {pend_tag, " R2 data"}, out_data, pend_data);
            check(out_sol === pend_sol && out_eol === pend_eol, "R3 markers",
                  {out_sol, out_eol}, {pend_sol, pend_eol});
        end else begin
            check(out_valid === 1'b0, {pend_tag, " no output"}, out_valid, 0);
        end
        in_valid = v;
        in_data  = d[9:0];
        in_sol   = s;
        in_eol   = e;
        corr_en  = cfg_en;
        thresh   = cfg_th[9:0];
        if (v) begin
            g_val[gj] = d;
            g_sol[gj] = s;
            g_eol[gj] = e;
            g_all[gj] = all_flag;
            if (gj >= 3) begin
                pend_valid = 1;
                pend_sol   = g_sol[gj-3];
                pend_eol   = g_eol[gj-3];
                expect_px(gj - 3, pend_data, pend_tag);
            end else begin
                pend_valid = 0;
                pend_tag   = "R1";
            end
            gj++;
        end else begin
            pend_valid = 0;
            pend_tag   = "R10";
        end
        @(negedge clk);
    endtask

    task automatic do_reset();
        in_valid = 0;
        rst = 1;
        repeat (2) @(negedge clk);
        rst = 0;
        gj = 0;
        pend_valid = 0;
        pend_tag = "R1";
        check(out_valid === 1'b0 && out_data === 10'd0, "R1 reset state",
              {out_valid, out_data}, 0);
    endtask

    // pat 0: random with idle gaps; 1: isolated spikes; 2: every same-colour pixel defective
    task automatic send_line(int len, int pat, int base);
        int val;
        for (int i = 0; i < len; i++) begin
            if (pat == 0) begin
                val = rnd() % 1024;
            end else if (pat == 1) begin
                if (i % 4 == 2) begin
                    case ((i / 4) % 5)
                        0: val = clamp(base + cfg_th + 1);
                        1: val = clamp(base + cfg_th);
                        2: val = clamp(base - cfg_th - 1);
                        3: val = clamp(base - cfg_th);
                        default: val = clamp(base + 600);
                    endcase
                end else if (i % 2 == 1) begin
                    val = clamp(base + 3);
                end else begin
                    val = base;
                end
            end else begin
                if (i % 4 == 0)      val = 1000;
                else if (i % 4 == 2) val = 10;
                else                 val = 500;
            end
            step(1, val, i == 0, i == len - 1, pat == 2);
            if (pat == 0 && (rnd() % 5 == 0)) step(0, 0, 0, 0, 0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog expired");
            $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    end

    initial begin
        int ths [4] = '{0, 1, 37, 1023};
        cfg_en = 1;
        cfg_th = 0;
        gj = 0;
        @(negedge clk);
        do_reset();
        for (int t = 0; t < 4; t++) begin
            for (int en = 1; en >= 0; en--) begin
                cfg_th = ths[t];
                cfg_en = en[0];
                for (int len = 1; len <= 14; len++) send_line(len, 0, 0);
                send_line(20, 1, 400);
                send_line(20, 1, 1000);
                send_line(20, 1, 5);
                send_line(16, 2, 0);
            end
        end
        // Reset in the middle of a stream, then resume (R1)
        cfg_en = 1;
        cfg_th = 20;
        send_line(7, 1, 300);
        do_reset();
        send_line(12, 1, 300);
        send_line(12, 2, 0);
        send_line(5, 0, 0);
        step(0, 0, 0, 0, 0);
        step(0, 0, 0, 0, 0);
        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    end
endmodule